// File: doc/BRIEF.md
# I2C Display Bridge Register Target

This block is an I2C target that presents the small register face of a display bridge. A host can read an identifier and a sink-present status from it. It can also run a two-bit request/grant handshake that switches a mode output. Logic around the block uses that output to steer the bus to a separate EDID target, and the host later clears it to take the bus back. Only a handful of registers return fixed values. Every other write is acknowledged and thrown away.

The block has three parts. A bit-level front end samples SCL and SDA through synchronisers on the system clock. It finds START, repeated START and STOP conditions, matches a 7-bit address, drives ACK and shifts bytes in and out. A byte-level register engine holds an auto-incrementing pointer, a flag marking that the next written byte is a pointer, the pending-request flag and the pass-through mode flag. SDA is open-drain: the block only ever pulls the line low.

Top module: `dbr_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal the DEV_ADDR parameter (default 0x39); bit 0 of that byte is 1 for read and 0 for write. A START with any other address is not acknowledged, and the block ignores the bus until the next START.
- R2: In a write transfer, the first data byte after the address (after any START or repeated START) becomes the register pointer and is written to no register.
- R3: The register pointer increases by one after each data byte read or written.
- R4: Reading register 0x1B returns 0xB0.
- R5: Reading register 0x3D returns 0x04.
- R6: Reading register 0x1A returns 0x06 while a request is pending and 0x00 when none is.
- R7: Writing 0x1A with bit 2 set records a pending request; if bit 1 is also set in the same byte, ddc_mode_o goes high.
- R8: Writing 0x1A with bit 2 clear cancels the request and drives ddc_mode_o low.
- R9: Reading any other register returns 0x00, and writing any other register changes no output.
- R10: Every data byte written to the block is acknowledged.
- R11: Reset releases SDA, drives ddc_mode_o low, clears the request and sets the pointer to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain drive) |
| ddc_mode_o | output | 1 | High while the bus should be routed to the EDID target |

## Verification
A table of single-register reads goes through the full pointer-write, repeated-START, read sequence for the chip identifier, the interrupt status, the idle system-control register and unlisted addresses. This separates the fixed-value decoding from the default-zero path. Directed transfers then exercise the handshake: request only, request with grant, then cancel. Each step reads back 0x1A, so a pending request can be told apart from an entered mode. Multi-byte reads and writes that cross from 0x19 into 0x1B show that the pointer increments after reads and after writes. A pointer-only frame, a foreign address and a reset in mid-mode show that bytes reach no register when they should not.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t SYSCTL_REG  = 8'h1A;
  localparam byte_t CHIPID_REG  = 8'h1B;
  localparam byte_t IRQSTAT_REG = 8'h3D;

  localparam byte_t CHIPID_VAL  = 8'hB0;
  localparam byte_t IRQSTAT_VAL = 8'h04;
  localparam byte_t SYSCTL_GNT  = 8'h06;

  localparam int REQ_BIT = 2;
  localparam int GNT_BIT = 1;

  typedef enum logic [2:0] {
    FE_IDLE, FE_ADDR, FE_AACK, FE_WDAT, FE_WACK, FE_RDAT, FE_RACK
  } fe_state_e;
endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/dbr_i2c_fe.sv
module dbr_i2c_fe
  import dbr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scl_s,
  input  logic  sda_s,
  input  byte_t rd_byte,
  output logic  sda_oe,
  output logic  ev_start,
  output logic  wr_stb,
  output byte_t wr_byte,
  output logic  rd_stb
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  fe_state_e  state, state_n;
  logic [3:0] cnt, cnt_n;
  byte_t      shreg, shreg_n;
  logic       rw, rw_n;
  logic       mack, mack_n;
  logic       oe_n;
  logic       scl_p, sda_p;
  logic       start_ev, stop_ev, rise, fall;

  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise     = scl_s & ~scl_p;
  assign fall     = ~scl_s & scl_p;
  assign wr_byte  = shreg;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    shreg_n  = shreg;
    rw_n     = rw;
    mack_n   = mack;
    oe_n     = sda_oe;
    ev_start = 1'b0;
    wr_stb   = 1'b0;
    rd_stb   = 1'b0;
    if (start_ev) begin
      state_n  = FE_ADDR;
      cnt_n    = 4'd0;
      oe_n     = 1'b0;
      ev_start = 1'b1;
    end else if (stop_ev) begin
      state_n = FE_IDLE;
      oe_n    = 1'b0;
    end else begin
      case (state)
        FE_ADDR, FE_WDAT: begin
          if (rise) begin
            shreg_n = {shreg[BYTE_W-2:0], sda_s};
            cnt_n   = cnt + 4'd1;
          end else if (fall && cnt == BITS_PER_BYTE) begin
            if (state == FE_WDAT) begin
              wr_stb  = 1'b1;
              state_n = FE_WACK;
              oe_n    = 1'b1;
            end else if (shreg[7:1] == DEV_ADDR) begin
              state_n = FE_AACK;
              rw_n    = shreg[0];
              oe_n    = 1'b1;
            end else begin
              state_n = FE_IDLE;
            end
          end
        end
        FE_AACK, FE_RACK: begin
          if (rise && state == FE_RACK) begin
            mack_n = ~sda_s;
          end else if (fall) begin
            cnt_n = 4'd0;
            if (state == FE_AACK && !rw) begin
              state_n = FE_WDAT;
              oe_n    = 1'b0;
            end else if (state == FE_AACK || mack) begin
              state_n = FE_RDAT;
              shreg_n = rd_byte;
              rd_stb  = 1'b1;
              oe_n    = ~rd_byte[BYTE_W-1];
            end else begin
              state_n = FE_IDLE;
              oe_n    = 1'b0;
            end
          end
        end
        FE_WACK: begin
          if (fall) begin
            state_n = FE_WDAT;
            cnt_n   = 4'd0;
            oe_n    = 1'b0;
          end
        end
        FE_RDAT: begin
          if (rise) begin
            cnt_n = cnt + 4'd1;
          end else if (fall) begin
            if (cnt == BITS_PER_BYTE) begin
              state_n = FE_RACK;
              oe_n    = 1'b0;
            end else begin
              shreg_n = {shreg[BYTE_W-2:0], 1'b0};
              oe_n    = ~shreg[BYTE_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FE_IDLE;
      cnt    <= 4'd0;
      shreg  <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      shreg  <= shreg_n;
      rw     <= rw_n;
      mack   <= mack_n;
      sda_oe <= oe_n;
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  // R10
  wack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == FE_WACK |-> sda_oe);

  // R1
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FE_AACK && $past(state) != FE_AACK) |-> $past(shreg[7:1]) == DEV_ADDR);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FE_IDLE && $past(state) == FE_IDLE) |-> !sda_oe);
endmodule

// File: rtl/dbr_regs.sv
module dbr_regs
  import dbr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_start,
  input  logic  wr_stb,
  input  byte_t wr_byte,
  input  logic  rd_stb,
  output byte_t rd_byte,
  output logic  ddc_mode
);
  byte_t ptr, ptr_n;
  logic  load_pend, load_n;
  logic  req, req_n;
  logic  mode_n;
  logic  ptr_en;

  assign ptr_en = wr_stb | rd_stb;

  always_comb begin
    ptr_n  = ptr;
    load_n = load_pend;
    req_n  = req;
    mode_n = ddc_mode;
    if (ev_start) load_n = 1'b1;
    if (wr_stb) begin
      if (load_pend) begin
        ptr_n  = wr_byte;
        load_n = 1'b0;
      end else begin
        if (ptr == SYSCTL_REG) begin
          if (wr_byte[REQ_BIT]) begin
            req_n = 1'b1;
            if (wr_byte[GNT_BIT]) mode_n = 1'b1;
          end else begin
            req_n  = 1'b0;
            mode_n = 1'b0;
          end
        end
        ptr_n = ptr + 8'd1;
      end
    end else if (rd_stb) begin
      ptr_n = ptr + 8'd1;
    end
  end

  always_comb begin
    case (ptr)
      SYSCTL_REG:  rd_byte = req ? SYSCTL_GNT : 8'h00;
      CHIPID_REG:  rd_byte = CHIPID_VAL;
      IRQSTAT_REG: rd_byte = IRQSTAT_VAL;
      default:     rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      load_pend <= 1'b0;
      req       <= 1'b0;
      ddc_mode  <= 1'b0;
    end else begin
      if (ptr_en) ptr <= ptr_n;
      load_pend <= load_n;
      req       <= req_n;
      ddc_mode  <= mode_n;
    end
  end

  // R3
  rd_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ptr == $past(ptr) + 8'd1);

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && load_pend) |=> (ptr == $past(wr_byte) && !load_pend && ddc_mode == $past(ddc_mode)));

  // R7
  mode_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_mode |-> req);

  // R8
  mode_drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ddc_mode) |-> $past(wr_stb) && $past(ptr) == SYSCTL_REG);
endmodule

// File: rtl/dbr_i2c_target.sv
module dbr_i2c_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic ddc_mode_o
);
  import dbr_pkg::*;

  logic [1:0] bus_s;
  logic       ev_start, wr_stb, rd_stb;
  byte_t      wr_byte, rd_byte;

  dbr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );

  dbr_i2c_fe #(.DEV_ADDR(DEV_ADDR)) u_fe (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .rd_byte(rd_byte), .sda_oe(sda_oe_o), .ev_start(ev_start),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb)
  );

  dbr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte),
    .ddc_mode(ddc_mode_o)
  );
endmodule

// File: tb/tb_dbr_i2c_target.sv
`timescale 1ns/1ps
module tb_dbr_i2c_target;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h39;
  localparam int NVEC = 6;
  // {register, expected read value}
  localparam logic [15:0] VEC [NVEC] = '{16'h1BB0, 16'h3D04, 16'h1A00,
                                         16'h0000, 16'h3C00, 16'hFF00};

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe_o, ddc_mode_o;
  logic sda_line;
  int   tests = 0;
  int   fails = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe_o;

  dbr_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .ddc_mode_o(ddc_mode_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_line;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic reg_write(input logic [7:0] ptr, input logic [7:0] d);
    logic a;
    i2c_start();
    put_byte({ADDR, 1'b0}, a); chk("R1 address ack", a, 1);
    put_byte(ptr, a);          chk("R10 pointer ack", a, 1);
    put_byte(d, a);            chk("R10 data ack", a, 1);
    i2c_stop();
  endtask

  task automatic reg_read(input logic [7:0] ptr, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] d;
    i2c_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(ptr, a);
    i2c_start();
    put_byte({ADDR, 1'b1}, a); chk("R1 read address ack", a, 1);
    get_byte(1'b0, d);
    i2c_stop();
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d, d2;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    w(5);
    // R11 reset state
    chk("R11 sda released in reset", sda_oe_o, 0);
    chk("R11 mode low in reset", ddc_mode_o, 0);
    rst_n = 1'b1; w(10);
    // R11 pointer at 0 after reset: current-address read
    i2c_start();
    put_byte({ADDR, 1'b1}, a);
    get_byte(1'b0, d);
    i2c_stop();
    chk("R11 reset pointer read", d, 8'h00);

    // table walk: R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++)
      reg_read(VEC[i][15:8], VEC[i][7:0], "R4/R5/R6/R9 table read");

    // R7 request only
    reg_write(8'h1A, 8'h04);
    w(4);
    chk("R7 request without grant keeps mode low", ddc_mode_o, 0);
    reg_read(8'h1A, 8'h06, "R6 pending request reads 0x06");
    // R7 request and grant
    reg_write(8'h1A, 8'h06);
    w(4);
    chk("R7 request+grant sets mode", ddc_mode_o, 1);
    // R9 write elsewhere ignored
    reg_write(8'h3D, 8'hFF);
    w(4);
    chk("R9 foreign write leaves mode", ddc_mode_o, 1);
    reg_read(8'h3D, 8'h04, "R9 foreign write leaves status");
    // R8 cancel
    reg_write(8'h1A, 8'h00);
    w(4);
    chk("R8 cancel clears mode", ddc_mode_o, 0);
    reg_read(8'h1A, 8'h00, "R8 cancel clears request");

    // R3 write auto increment: 0x19 (ignored) then 0x1A
    i2c_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h19, a);
    put_byte(8'h00, a); chk("R10 ack on ignored register", a, 1);
    put_byte(8'h06, a);
    i2c_stop();
    w(4);
    chk("R3 write increments into 0x1A", ddc_mode_o, 1);

    // R3 read auto increment: 0x1A then 0x1B
    i2c_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h1A, a);
    i2c_start();
    put_byte({ADDR, 1'b1}, a);
    get_byte(1'b1, d);
    get_byte(1'b0, d2);
    i2c_stop();
    chk("R3 first read byte", d, 8'h06);
    chk("R3 second read byte", d2, 8'hB0);

    // clear mode, leave pointer at 0x1A via ignored write to 0x19
    reg_write(8'h1A, 8'h00);
    reg_write(8'h19, 8'h00);
    // R2 pointer-only frame must not write
    i2c_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h06, a);
    i2c_stop();
    w(4);
    chk("R2 first byte not written", ddc_mode_o, 0);
    // R2 repeated START re-arms pointer load
    reg_write(8'h19, 8'h00);
    i2c_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h1A, a);
    i2c_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h06, a);
    i2c_stop();
    w(4);
    chk("R2 repeated START byte is pointer", ddc_mode_o, 0);

    // R1 wrong address ignored
    i2c_start();
    put_byte({7'h3A, 1'b0}, a);
    chk("R1 foreign address nack", a, 0);
    put_byte(8'h1A, a);
    put_byte(8'h06, a);
    i2c_stop();
    w(4);
    chk("R1 foreign frame ignored", ddc_mode_o, 0);

    // R11 reset during mode
    reg_write(8'h1A, 8'h06);
    w(4);
    chk("R7 mode set before reset", ddc_mode_o, 1);
    rst_n = 1'b0; w(3);
    chk("R11 reset clears mode", ddc_mode_o, 0);
    rst_n = 1'b1; w(10);
    reg_read(8'h1A, 8'h00, "R11 reset clears request");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule